// File: doc/BRIEF.md
# Serial Field Memory Read Port Controller

This block drives the read side of a serial field-delay memory. It keeps a read pointer that addresses a dual-port storage array and registers the word the array returns onto an 8-bit output. A drive flag stands in for a three-state bus: data is meaningful only while the flag is high, and the data pins are forced to zero otherwise. It has its own read clock and needs no link to the write side.

Two independent enables control the stream. The advance enable moves the pointer. The output enable decides whether the bus is driven. Because they are independent, a consumer can skip words (the pointer moves while the bus is released) or pause the stream (the pointer holds while the last word stays on the bus). A restart strobe returns the pointer to zero. The strobe must stay quiet for at least two read cycles between uses, and the block reports any shorter gap. A polarity strap lets the whole control group be active-low.

Top module: `fmr_read_port`

## Requirements
- R1: After the asynchronous reset is released, the address is 0, the drive flag is low, the data output is 0 and the gap error is low.
- R2: A clock edge that samples the restart strobe active sets the address to 0 and the drive flag low. Both enables are ignored on that edge, and the held word is not changed.
- R3: With both enables active, an edge loads the array word at the current address into the output register, advances the address by one and drives the bus. The data shows the word of the address presented before that edge.
- R4: With the advance enable active and the output enable inactive, the address advances and the word register loads, but the drive flag is low.
- R5: With the advance enable inactive and the output enable active, the address holds and the bus keeps driving the word already held.
- R6: With both enables inactive, the address holds and the drive flag is low.
- R7: When the polarity strap is 1, the restart strobe and both enables are active at level 0. When the strap is 0, they are active at level 1.
- R8: Advancing from address DEPTH-1 gives address 0.
- R9: An active restart sample that comes after fewer than two inactive samples since the previous active sample raises the gap error for exactly one cycle. The restart still takes effect.
- R10: While the drive flag is low, the data output is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pol_inv_i | input | 1 | Polarity strap: 1 makes all controls active-low |
| rd_en_i | input | 1 | Advance enable (pointer increment) |
| out_en_i | input | 1 | Output enable (bus drive) |
| rd_rst_i | input | 1 | Restart strobe, returns the pointer to zero |
| mem_addr_o | output | ADDR_W | Read address into the storage array |
| mem_data_i | input | DATA_W | Array word for mem_addr_o, available in the same cycle |
| dout_o | output | DATA_W | Registered output word, zero while not driving |
| drive_o | output | 1 | High when the output bus is driven |
| gap_err_o | output | 1 | One-cycle pulse on a restart that came too soon |

## Verification
The properties treat the array as combinational, so mem_data_i must follow mem_addr_o within the same cycle. The bench meets this with a computed lookup that it evaluates continuously. The gap properties compare against the previous cycle's strobe, so the strobe must be inactive while reset is held and during the short synchronised release that follows. The bench keeps every control inactive until several cycles after release. It changes the polarity strap only between scenarios, and only while the strobe and both enables are inactive at the new polarity.

// File: rtl/fmr_pkg.sv
package fmr_pkg;
  // Decoded (polarity-corrected) read controls, all active high.
  typedef struct packed {
    logic restart;
    logic advance;
    logic show;
  } fmr_ctl_t;
endpackage

// File: rtl/fmr_rst_sync.sv
module fmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/fmr_ctl_decode.sv
module fmr_ctl_decode
  import fmr_pkg::*;
(
  input  logic     pol_inv_i,
  input  logic     rd_en_i,
  input  logic     out_en_i,
  input  logic     rd_rst_i,
  output fmr_ctl_t ctl_o
);
  // A strap value of 1 turns every control active-low.
  always_comb begin
    ctl_o.restart = rd_rst_i ^ pol_inv_i;
    ctl_o.advance = rd_en_i  ^ pol_inv_i;
    ctl_o.show    = out_en_i ^ pol_inv_i;
  end
endmodule

// File: rtl/fmr_rd_ptr.sv
module fmr_rd_ptr
  import fmr_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fmr_ctl_t          ctl_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              ptr_en;

  always_comb begin
    ptr_en = ctl_i.restart | ctl_i.advance;
    if (ctl_i.restart)      ptr_d = '0;
    else if (ptr_q == LAST) ptr_d = '0;
    else                    ptr_d = ptr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/fmr_gap_mon.sv
module fmr_gap_mon #(
  parameter int MIN_GAP = 2,
  parameter int CNT_W   = $clog2(MIN_GAP + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic err_o
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(MIN_GAP);

  logic [CNT_W-1:0] quiet_q, quiet_d;
  logic             err_q, err_d;

  always_comb begin
    if (restart_i) begin
      err_d   = (quiet_q < SAT);
      quiet_d = '0;
    end else begin
      err_d   = 1'b0;
      quiet_d = (quiet_q == SAT) ? quiet_q : quiet_q + CNT_W'(1);
    end
  end

  // The count starts saturated, so the first restart is always legal.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_q <= SAT;
      err_q   <= 1'b0;
    end else begin
      quiet_q <= quiet_d;
      err_q   <= err_d;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/fmr_out_stage.sv
module fmr_out_stage
  import fmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fmr_ctl_t          ctl_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              drive_o
);
  logic [DATA_W-1:0] word_q;
  logic              drive_q, drive_d;
  logic              word_en;

  always_comb begin
    word_en = ctl_i.advance & ~ctl_i.restart;
    drive_d = ctl_i.show & ~ctl_i.restart;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (word_en) word_q <= mem_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drive_q <= 1'b0;
    else         drive_q <= drive_d;
  end

  assign drive_o = drive_q;
  assign dout_o  = drive_q ? word_q : '0;
endmodule

// File: rtl/fmr_read_port.sv
module fmr_read_port
  import fmr_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int DATA_W  = 8,
  parameter int MIN_GAP = 2,
  parameter int ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pol_inv_i,
  input  logic              rd_en_i,
  input  logic              out_en_i,
  input  logic              rd_rst_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              drive_o,
  output logic              gap_err_o
);
  logic     rst_n_s;
  fmr_ctl_t ctl;

  fmr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_s)
  );

  fmr_ctl_decode u_dec (
    .pol_inv_i (pol_inv_i),
    .rd_en_i   (rd_en_i),
    .out_en_i  (out_en_i),
    .rd_rst_i  (rd_rst_i),
    .ctl_o     (ctl)
  );

  fmr_rd_ptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .ctl_i  (ctl),
    .ptr_o  (mem_addr_o)
  );

  fmr_gap_mon #(.MIN_GAP(MIN_GAP)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .restart_i (ctl.restart),
    .err_o     (gap_err_o)
  );

  fmr_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .ctl_i      (ctl),
    .mem_data_i (mem_data_i),
    .dout_o     (dout_o),
    .drive_o    (drive_o)
  );
endmodule

// File: rtl/fmr_read_port_chk.sv
module fmr_read_port_chk #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pol_inv_i,
  input logic              rd_en_i,
  input logic              out_en_i,
  input logic              rd_rst_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] dout_o,
  input logic              drive_o,
  input logic              gap_err_o
);
  logic rs_a, adv_a, show_a;
  assign rs_a   = rd_rst_i ^ pol_inv_i;
  assign adv_a  = rd_en_i  ^ pol_inv_i;
  assign show_a = out_en_i ^ pol_inv_i;

  // R2
  ptr_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_a |=> (mem_addr_o == '0) && !drive_o);

  // R5
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rs_a && !adv_a) |=> $stable(mem_addr_o));

  // R8
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rs_a && adv_a) |=> mem_addr_o == (($past(mem_addr_o) == ADDR_W'(DEPTH - 1)) ?
                                        ADDR_W'(0) : $past(mem_addr_o) + ADDR_W'(1)));

  // R4
  drive_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rs_a |=> drive_o == $past(show_a));

  // R10
  bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> dout_o == '0);

  // R5
  pause_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && !rs_a && !adv_a && show_a) |=> $stable(dout_o));

  // R9
  gap_flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_err_o |-> $past(rs_a));

  // R9
  gap_flag_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_a && $past(rs_a)) |=> gap_err_o);
endmodule

bind fmr_read_port fmr_read_port_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pol_inv_i  (pol_inv_i),
  .rd_en_i    (rd_en_i),
  .out_en_i   (out_en_i),
  .rd_rst_i   (rd_rst_i),
  .mem_addr_o (mem_addr_o),
  .dout_o     (dout_o),
  .drive_o    (drive_o),
  .gap_err_o  (gap_err_o)
);

// File: tb/fmr_read_port_tb.sv
module fmr_read_port_tb_top;
  localparam int DEPTH  = 64;
  localparam int DATA_W = 8;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              pol_inv_i;
  logic              rd_en_i, out_en_i, rd_rst_i;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [DATA_W-1:0] mem_data_i;
  logic [DATA_W-1:0] dout_o;
  logic              drive_o, gap_err_o;

  int checks = 0;
  int errors = 0;

  // Reference state, derived from the requirements
  int   m_ptr;
  int   m_word;
  logic m_drive;
  logic m_err;
  int   m_quiet;
  logic inv;

  always #4 clk_i = ~clk_i;

  function automatic logic [DATA_W-1:0] memf(int a);
    return DATA_W'(a * 37 + 11);
  endfunction

  always_comb mem_data_i = memf(int'(mem_addr_o));

  fmr_read_port #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pol_inv_i(pol_inv_i),
    .rd_en_i(rd_en_i), .out_en_i(out_en_i), .rd_rst_i(rd_rst_i),
    .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
    .dout_o(dout_o), .drive_o(drive_o), .gap_err_o(gap_err_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "addr",  int'(mem_addr_o), m_ptr);
    chk(tag, "drive", int'(drive_o), int'(m_drive));
    chk(tag, "dout",  int'(dout_o), m_drive ? m_word : 0);
    chk(tag, "gap_err", int'(gap_err_o), int'(m_err));
  endtask

  // One read cycle: controls given as active-high, encoded through the strap.
  task automatic step(logic re, logic oe, logic rs, string tag);
    rd_en_i  = re ^ inv;
    out_en_i = oe ^ inv;
    rd_rst_i = rs ^ inv;
    @(posedge clk_i);
    if (rs) begin
      m_err   = (m_quiet < 2);
      m_ptr   = 0;
      m_drive = 1'b0;
      m_quiet = 0;
    end else begin
      m_err   = 1'b0;
      m_quiet = (m_quiet >= 2) ? 2 : m_quiet + 1;
      if (re) begin
        m_word = int'(memf(m_ptr));
        m_ptr  = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
      end
      m_drive = oe;
    end
    @(negedge clk_i);
    check_all(tag);
  endtask

  task automatic t_reset_state;
    check_all("R1");
  endtask

  task automatic t_stream;
    step(0, 0, 1, "R2");
    step(0, 0, 0, "R6");
    for (int i = 0; i < 6; i++) step(1, 1, 0, "R3");
  endtask

  task automatic t_skip;
    for (int i = 0; i < 4; i++) step(1, 0, 0, "R4");
    chk("R10", "dout while released", int'(dout_o), 0);
    step(1, 1, 0, "R3");
  endtask

  task automatic t_pause;
    for (int i = 0; i < 4; i++) step(0, 1, 0, "R5");
    step(1, 1, 0, "R3");
  endtask

  task automatic t_idle;
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R6");
    chk("R10", "dout idle", int'(dout_o), 0);
  endtask

  task automatic t_restart_ignores;
    step(1, 1, 0, "R3");
    step(1, 1, 1, "R2");
    step(0, 0, 0, "R6");
    step(0, 0, 0, "R6");
    step(0, 1, 1, "R2");
    step(0, 0, 0, "R6");
    step(0, 0, 0, "R6");
  endtask

  task automatic t_wrap;
    step(0, 0, 1, "R2");
    for (int i = 0; i < DEPTH + 3; i++) step(1, 1, 0, "R8");
  endtask

  task automatic t_gap;
    step(0, 0, 0, "R9");
    step(0, 0, 0, "R9");
    step(0, 0, 1, "R9");
    step(1, 1, 0, "R9");
    step(0, 0, 1, "R9");
    step(0, 0, 1, "R9");
    step(0, 0, 0, "R9");
    step(0, 0, 0, "R9");
    step(0, 0, 1, "R9");
    step(0, 0, 0, "R9");
  endtask

  task automatic t_polarity;
    // Move all raw controls to the new idle level, then flip the strap.
    @(negedge clk_i);
    rd_en_i = 1'b1; out_en_i = 1'b1; rd_rst_i = 1'b1;
    pol_inv_i = 1'b1; inv = 1'b1;
    step(0, 0, 0, "R7");
    step(0, 0, 0, "R7");
    step(0, 0, 1, "R7");
    step(0, 0, 0, "R7");
    step(0, 0, 0, "R7");
    for (int i = 0; i < 3; i++) step(1, 1, 0, "R7");
    step(1, 0, 0, "R7");
    step(0, 1, 0, "R7");
    step(0, 0, 0, "R7");
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    inv = 1'b0; pol_inv_i = 1'b0;
    rd_en_i = 1'b0; out_en_i = 1'b0; rd_rst_i = 1'b0;
    m_ptr = 0; m_word = 0; m_drive = 1'b0; m_err = 1'b0; m_quiet = 2;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset_state();
    t_stream();
    t_skip();
    t_pause();
    t_idle();
    t_restart_ignores();
    t_wrap();
    t_gap();
    t_polarity();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule